// File: doc/BRIEF.md
# Pipelined Bus Wait-State Generator

This block sits on the memory side of a pipelined processor bus. The clock runs freely. The block makes slow memory look ready by holding an active-low wait line LOW for as many whole clocks as the access needs. The processor presents the request, its sequential flag and the address one bus cycle before the matching data transfer. The generator therefore captures those inputs only on the rising edge that ends a bus cycle. That captured access owns the following data phase, and a wait counter is loaded for it.

During the data phase the processor may already drive the next, unrelated address. Because nothing is captured while the wait line is LOW, the latched address keeps pointing at the access whose data is moving. The wait line comes from a falling-edge register, so it only changes while the clock is LOW and is steady at every rising edge. The counter is purely static and has no timeout, so a bus cycle may be held for as long as the wait count asks.

Two configuration inputs choose the wait count for nonsequential and sequential accesses (0 to 15 each). A one-clock-wide data strobe marks the completing edge of every memory data phase.

Top module: `bus_wait_gen`

## Requirements
- R1: While synchronous reset `rst_n` is LOW, and at the first sampling edge after it is applied, `wait_n` is HIGH, `data_strobe` is LOW and `addr_lat` is zero, even if a stretched access was in progress.
- R2: A nonsequential access (`mreq`=1, `seq`=0 at the completing edge of its address phase) holds `wait_n` LOW at exactly `n_wait_cfg` rising edges of its data phase, so that data phase lasts `n_wait_cfg`+1 clocks.
- R3: A sequential access (`mreq`=1, `seq`=1) uses `s_wait_cfg` instead of `n_wait_cfg` in the same way.
- R4: `addr_lat` is loaded from `addr_in` only at a rising edge where `wait_n` is HIGH. Throughout the following data phase it equals the address that was presented at that edge, whatever `addr_in` does.
- R5: When `mreq`=0 at a completing edge, the next bus cycle has no waits and lasts one clock.
- R6: `data_strobe` is HIGH at a rising edge exactly when that edge completes the data phase of a memory access (`mreq` was 1 when it was captured). It is LOW at wait edges and in idle cycles.
- R7: With a wait count of zero, consecutive memory accesses complete on consecutive rising edges with no idle clock between them.
- R8: `wait_n` never changes across a rising edge: its value just after each rising edge equals its value just before it.
- R9: The largest count, 15, gives exactly 15 wait edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mreq | input | 1 | Memory request for the next bus cycle |
| seq | input | 1 | Next access is sequential to the previous one |
| addr_in | input | ADDR_W | Address for the next bus cycle |
| n_wait_cfg | input | CNT_W | Wait count for nonsequential accesses |
| s_wait_cfg | input | CNT_W | Wait count for sequential accesses |
| wait_n | output | 1 | Active-low wait to the processor, changed on falling edges |
| addr_lat | output | ADDR_W | Address of the access in its data phase |
| data_strobe | output | 1 | HIGH for the final clock of each memory data phase |

## Verification
Several properties are checked at every rising edge. The counter steps down by one at each wait edge. A LOW wait always implies a pending access with a nonzero count. The latched address holds still while a bus cycle is stretched and picks up the presented address when the cycle completes. An idle completion is followed by neither a wait nor a strobe. The exact length of each data phase under both counts, the timing of the strobe, back-to-back zero-wait accesses, the extreme count and reset in the middle of a stretch can only be shown by the bench's scenarios, which measure bus-cycle lengths edge by edge against counts derived from the configuration.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  localparam int unsigned WSG_MAX_CNT_W = 8;

  // Wait count owed by the access captured at a completing edge
  function automatic logic [WSG_MAX_CNT_W-1:0] wait_need(
    input logic                     req,
    input logic                     is_seq,
    input logic [WSG_MAX_CNT_W-1:0] ncnt,
    input logic [WSG_MAX_CNT_W-1:0] scnt
  );
    logic [WSG_MAX_CNT_W-1:0] r;
    if (!req)       r = '0;
    else if (is_seq) r = scnt;
    else            r = ncnt;
    return r;
  endfunction

endpackage

// File: rtl/wsg_capture.sv
module wsg_capture #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              mreq,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              active,
  output logic [ADDR_W-1:0] addr_q
);

  // Address and request are taken only when a bus cycle completes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      addr_q <= '0;
    end else if (done) begin
      active <= mreq;
      addr_q <= addr_in;
    end
  end

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(addr_q)); // R4

  AST_TAKE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> addr_q == $past(addr_in)); // R4

endmodule

// File: rtl/wsg_counter.sv
module wsg_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (done)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign cnt_zero = (cnt == '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R2

endmodule

// File: rtl/wsg_wait_drive.sv
module wsg_wait_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  output logic wait_n
);

  // Falling-edge register: the line only moves in the clock-low phase
  always_ff @(negedge clk) begin
    if (!rst_n)
      wait_n <= 1'b1;
    else
      wait_n <= !hold_req;
  end

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreq,
  input  logic              seq,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [CNT_W-1:0]  n_wait_cfg,
  input  logic [CNT_W-1:0]  s_wait_cfg,
  output logic              wait_n,
  output logic [ADDR_W-1:0] addr_lat,
  output logic              data_strobe
);
  import wsg_pkg::*;

  localparam int unsigned PAD_W = WSG_MAX_CNT_W - CNT_W;

  // Named internal events
  logic                     cycle_done;
  logic                     active;
  logic [CNT_W-1:0]         cnt;
  logic                     cnt_zero;
  logic                     hold_req;
  logic [WSG_MAX_CNT_W-1:0] need_full;
  logic [CNT_W-1:0]         need;

  assign cycle_done = wait_n;
  assign need_full  = wait_need(mreq, seq,
                                {{PAD_W{1'b0}}, n_wait_cfg},
                                {{PAD_W{1'b0}}, s_wait_cfg});
  assign need       = need_full[CNT_W-1:0];
  assign hold_req   = active && !cnt_zero;

  wsg_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (cycle_done),
    .mreq    (mreq),
    .addr_in (addr_in),
    .active  (active),
    .addr_q  (addr_lat)
  );

  wsg_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (cycle_done),
    .load_val (need),
    .cnt      (cnt),
    .cnt_zero (cnt_zero)
  );

  wsg_wait_drive u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_req (hold_req),
    .wait_n   (wait_n)
  );

  assign data_strobe = active && wait_n;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_n |-> (active && cnt != '0)); // R2

  AST_IDLE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_n && !mreq) |=> wait_n); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_n && !mreq) |=> !data_strobe); // R6

endmodule

// File: tb/bus_wait_gen_bench.sv
module bus_wait_gen_bench;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 4;
  localparam int NROWS  = 11;

  // row: {mreq, seq, ncfg[3:0], scfg[3:0], addr[15:0]}
  localparam logic [25:0] VEC [NROWS] = '{
    {1'b1, 1'b0, 4'd3,  4'd1, 16'h1000},
    {1'b1, 1'b1, 4'd3,  4'd1, 16'h1004},
    {1'b1, 1'b1, 4'd3,  4'd1, 16'h1008},
    {1'b0, 1'b0, 4'd3,  4'd1, 16'h5555},
    {1'b1, 1'b0, 4'd0,  4'd0, 16'h2000},
    {1'b1, 1'b1, 4'd0,  4'd0, 16'h2004},
    {1'b1, 1'b1, 4'd0,  4'd0, 16'h2008},
    {1'b1, 1'b0, 4'd15, 4'd2, 16'h3000},
    {1'b0, 1'b1, 4'd15, 4'd2, 16'h3004},
    {1'b1, 1'b0, 4'd2,  4'd0, 16'h4000},
    {1'b0, 1'b0, 4'd0,  4'd0, 16'h0000}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mreq = 1'b0;
  logic              seq = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [CNT_W-1:0]  n_wait_cfg = '0;
  logic [CNT_W-1:0]  s_wait_cfg = '0;
  logic              wait_n;
  logic [ADDR_W-1:0] addr_lat;
  logic              data_strobe;

  int checks = 0;
  int errors = 0;
  int prev_exp = 0;
  logic prev_req = 1'b0;
  logic [ADDR_W-1:0] prev_addr = '0;

  always #5 clk = ~clk;

  bus_wait_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bus_wait_gen (
    .clk(clk), .rst_n(rst_n), .mreq(mreq), .seq(seq), .addr_in(addr_in),
    .n_wait_cfg(n_wait_cfg), .s_wait_cfg(s_wait_cfg),
    .wait_n(wait_n), .addr_lat(addr_lat), .data_strobe(data_strobe)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Entered at rising edge + 1; returns at the completing edge + 1
  task automatic bus_cycle(input logic r, input logic s, input logic [3:0] nc,
                           input logic [3:0] sc, input logic [ADDR_W-1:0] a);
    int lows = 0;
    logic w;
    mreq = r; seq = s; n_wait_cfg = nc; s_wait_cfg = sc; addr_in = a;
    for (int e = 0; e < 40; e++) begin
      @(negedge clk); #4;
      w = wait_n;
      check("R4", "addr_lat during data phase", addr_lat, prev_addr);
      if (w) check("R6", "strobe at completing edge", data_strobe, prev_req);
      else   check("R6", "strobe low at wait edge", data_strobe, 0);
      // next address appears while the current access is stretched
      if (!w) addr_in = a;
      @(posedge clk); #1;
      check("R8", "wait_n steady across rising edge", wait_n, w);
      if (w) break;
      lows++;
    end
    if (!prev_req)
      check("R5", "idle cycle wait edges", lows, 0);
    else if (prev_exp == 0)
      check("R7", "zero-wait access wait edges", lows, 0);
    else if (prev_exp == 15)
      check("R9", "max-count wait edges", lows, 15);
    else
      check(prev_exp == int'(prev_req ? prev_exp : 0) ? "R2" : "R3",
            "wait edges", lows, prev_exp);
    prev_req  = r;
    prev_addr = a;
    prev_exp  = r ? int'(s ? sc : nc) : 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #4;
    check("R1", "wait_n in reset", wait_n, 1);
    check("R1", "strobe in reset", data_strobe, 0);
    check("R1", "addr_lat in reset", addr_lat, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // Table walk: each row's waits are measured in the next row's cycle
    for (int i = 0; i < NROWS; i++)
      bus_cycle(VEC[i][25], VEC[i][24], VEC[i][23:20], VEC[i][19:16],
                {16'h0, VEC[i][15:0]});

    // R3 directed: sequential count differs from nonsequential
    bus_cycle(1'b1, 1'b1, 4'd9, 4'd4, 32'hA0);
    bus_cycle(1'b0, 1'b0, 4'd0, 4'd0, 32'h0);
    check("R3", "sequential count used", prev_exp, 0);

    // R1 directed: reset in the middle of a 15-wait stretch
    bus_cycle(1'b1, 1'b0, 4'd15, 4'd0, 32'hBEEF);
    mreq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #4;
    check("R2", "still stretched before reset", wait_n, 0);
    @(posedge clk); #1;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk); #4;
    check("R1", "wait_n after mid-stretch reset", wait_n, 1);
    check("R1", "strobe after mid-stretch reset", data_strobe, 0);
    check("R1", "addr_lat after mid-stretch reset", addr_lat, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    prev_req = 1'b0; prev_addr = '0; prev_exp = 0;
    bus_cycle(1'b1, 1'b0, 4'd1, 4'd0, 32'hC0);
    bus_cycle(1'b0, 1'b0, 4'd0, 4'd0, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule